// File: doc/BRIEF.md
# Sync Activity Detector

This block decides whether each of two sync lines is active. One line carries a pixel clock or a horizontal sync, and the other carries a vertical sync. Both lines reach the block already retimed into the crystal-clock domain. Inside a programmable sampling window the block counts the rising transitions on each line. It then compares each count with a programmable minimum and reports one activity bit per line.

Software controls the block through a small byte-wide register port. Each sampling window is set by a 16-bit value, and its length is that value times 256 crystal clocks. The vertical window must be programmed longer than the horizontal one, because a measurement ends when the vertical window expires. At that point the two activity bits are captured and a polling flag flips, which tells the controller that a new result is ready.

There are two ways to run the block. In single-shot mode, one measurement runs for each start command, and the start bit clears itself when the measurement finishes. In continuous mode, measurements follow one another without a gap for as long as the run bit is set. A hold bit can freeze the reported results in continuous mode while the polling flag keeps flipping.

Top module: `sync_activity_detector`

## Requirements
- R1: After reset, every register reads 0, and the `hs_active`, `vs_active` and `poll_flag` outputs are all 0.
- R2: The register addresses are:
  - 0: control. Bit 0 selects the mode (1 = single shot, 0 = continuous). Bit 1 is the start bit. Bit 2 is the hold bit. Bit 3 is the run bit. Bits [7:4] always read 0.
  - 1 and 2: horizontal window, low byte then high byte.
  - 3 and 4: vertical window, low byte then high byte.
  - 5: horizontal minimum edge count.
  - 6: vertical minimum edge count.
  - 7: read-only status. Bit 0 is the horizontal result, bit 1 is the vertical result, bit 2 is the polling flag, and the other bits read 0. Writes to address 7 have no effect.
- R3: In single-shot mode, a write that sets the start bit begins one measurement. The measurement lasts exactly vwin*256 clocks after the write edge. On its final edge the start bit reads back 0. No further measurement follows until software sets the start bit again.
- R4: In continuous mode with the run bit set, measurements repeat back to back, each vwin*256 clocks long, starting from the write edge. Clearing the run bit stops them, and no further polling toggle occurs.
- R5: A line is reported active when its count of rising edges reaches its minimum. Reaching the minimum exactly counts as active, and one edge fewer does not. A minimum of 0 reports active even when the line has no edges at all.
- R6: A horizontal edge counts only when it is sampled within the first hwin*256 clocks of the measurement. Edge 256 of a 1-unit window counts, and edge 257 does not. Vertical edges count over the whole measurement.
- R7: Edge counters saturate at 255 and do not wrap. With 300 edges and a minimum of 255, the line reads active.
- R8: On the final edge of each measurement, `poll_flag` inverts and the results update together. Neither changes at any other time.
- R9: In continuous mode with the hold bit set, the results keep their previous values at the end of each measurement, while `poll_flag` still toggles. Clearing the hold bit lets the next result through.
- R10: The hold bit has no effect in single-shot mode. The results update even when the hold bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Retimed clock/horizontal sync line |
| vs_in | input | 1 | Retimed vertical sync line |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| hs_active | output | 1 | Latched horizontal activity result |
| vs_active | output | 1 | Latched vertical activity result |
| poll_flag | output | 1 | Toggles once per finished measurement |

## Verification
The detector is driven with pulse trains of chosen length and position.

- Counts one below, at and above each minimum tell the threshold rule apart from an off-by-one comparison.
- Single pulses placed on the last clock inside the horizontal window, and on the first clock after it, pin down the window edge.
- A 300-pulse burst against a minimum of 255 separates saturation from wrap-around.
- A zero minimum with no edges shows that the comparison is "at least".
- In continuous mode, the result pattern changes from one window to the next while the hold bit is switched. This tells held results apart from fresh ones and confirms that every polling toggle lands exactly one window length after the previous one.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
package sad_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int WIN_W  = 2 * DATA_W;
  localparam int NCH    = 2;
  localparam int NCFG   = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

  // Field order matches control bits [3:0].
  typedef struct packed {
    logic run;
    logic hold;
    logic start;
    logic oneshot;
  } ctrl_t;
endpackage

// File: rtl/sad_regs.sv
`timescale 1ns/1ps
module sad_regs
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              meas_done,
  input  logic [NCH-1:0]    act,
  input  logic              poll,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [WIN_W-1:0]  hwin,
  output logic [WIN_W-1:0]  vwin,
  output logic [DATA_W-1:0] hmin,
  output logic [DATA_W-1:0] vmin
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] cfg_q [NCFG];
  logic [DATA_W-1:0] cfg_d [NCFG];
  logic              ctrl_we;

  assign ctrl_we = wr_en && (addr == A_CTRL);

  // Control: software write first, then self-clear of start at the end of a single shot.
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wdata[3:0]);
    if (meas_done && ctrl_q.oneshot) ctrl_d.start = 1'b0;
  end

  always_comb begin
    for (int k = 0; k < NCFG; k++) begin
      cfg_d[k] = cfg_q[k];
      if (wr_en && (addr == ADDR_W'(k + 1))) cfg_d[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int k = 0; k < NCFG; k++) cfg_q[k] <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      for (int k = 0; k < NCFG; k++) cfg_q[k] <= cfg_d[k];
    end
  end

  assign ctrl = ctrl_q;
  assign hwin = {cfg_q[1], cfg_q[0]};
  assign vwin = {cfg_q[3], cfg_q[2]};
  assign hmin = cfg_q[4];
  assign vmin = cfg_q[5];

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)      rdata = {{(DATA_W-4){1'b0}}, ctrl_q};
    else if (addr == A_STAT) rdata = {{(DATA_W-NCH-1){1'b0}}, poll, act};
    else                     rdata = cfg_q[addr - ADDR_W'(1)];
  end
endmodule

// File: rtl/sad_timer.sv
`timescale 1ns/1ps
module sad_timer #(
  parameter int PRE_W = 8,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIN_W-1:0] hwin,
  input  logic [WIN_W-1:0] vwin,
  output logic             h_open,
  output logic             done
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [WIN_W-1:0] unit_q, unit_d;
  logic             pre_wrap;

  assign pre_wrap = &pre_q;
  assign h_open   = unit_q < hwin;
  // The measurement ends on the last clock of the vertical window (a value of 0 wraps to the full range).
  assign done     = run && pre_wrap && (unit_q == (vwin - WIN_W'(1)));

  always_comb begin
    pre_d  = pre_q;
    unit_d = unit_q;
    if (!run || done) begin
      pre_d  = '0;
      unit_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
      if (pre_wrap) unit_d = unit_q + WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end
endmodule

// File: rtl/sad_edge_chan.sv
`timescale 1ns/1ps
module sad_edge_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             run,
  input  logic             win_open,
  input  logic             done,
  input  logic [CNT_W-1:0] min_cnt,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sum;
  logic             rise, inc;

  assign rise    = sync_in & ~prev_q;
  assign inc     = rise & run & win_open & ~(&cnt_q);
  assign cnt_sum = cnt_q + CNT_W'(inc);
  assign hit     = cnt_sum >= min_cnt;

  always_comb begin
    cnt_d = cnt_sum;
    if (!run || done) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sync_in;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sad_result.sv
`timescale 1ns/1ps
module sad_result #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done,
  input  logic           hold,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] act,
  output logic           poll
);
  logic [NCH-1:0] act_q, act_d;
  logic           poll_q, poll_d;
  logic           cap_en;

  assign cap_en = done & ~hold;

  always_comb begin
    act_d  = cap_en ? hit : act_q;
    poll_d = poll_q ^ done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      poll_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      poll_q <= poll_d;
    end
  end

  assign act  = act_q;
  assign poll = poll_q;
endmodule

// File: rtl/sync_activity_detector.sv
`timescale 1ns/1ps
module sync_activity_detector
  import sad_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hs_active,
  output logic              vs_active,
  output logic              poll_flag
);
  logic [1:0]        rs_q;
  logic              rst_int_n;
  ctrl_t             ctrl_w;
  logic [WIN_W-1:0]  hwin_w, vwin_w;
  logic [DATA_W-1:0] hmin_w, vmin_w;
  logic              run_w, hold_w, h_open, meas_done;
  logic [NCH-1:0]    sync_w, open_w, hit_w, act_w;
  logic [DATA_W-1:0] min_w [NCH];
  logic [DATA_W-1:0] cnt_w [NCH];
  logic              poll_w;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  sad_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .meas_done(meas_done), .act(act_w), .poll(poll_w), .rdata(rdata),
    .ctrl(ctrl_w), .hwin(hwin_w), .vwin(vwin_w), .hmin(hmin_w), .vmin(vmin_w)
  );

  assign run_w  = ctrl_w.oneshot ? ctrl_w.start : ctrl_w.run;
  assign hold_w = ctrl_w.hold & ~ctrl_w.oneshot;

  sad_timer #(.PRE_W(PRE_W), .WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(run_w), .hwin(hwin_w), .vwin(vwin_w),
    .h_open(h_open), .done(meas_done)
  );

  assign sync_w   = {vs_in, hs_in};
  assign open_w   = {1'b1, h_open};
  assign min_w[0] = hmin_w;
  assign min_w[1] = vmin_w;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sad_edge_chan #(.CNT_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_int_n), .sync_in(sync_w[c]), .run(run_w),
      .win_open(open_w[c]), .done(meas_done), .min_cnt(min_w[c]),
      .cnt(cnt_w[c]), .hit(hit_w[c])
    );
  end

  sad_result #(.NCH(NCH)) u_result (
    .clk(clk), .rst_n(rst_int_n), .done(meas_done), .hold(hold_w),
    .hit(hit_w), .act(act_w), .poll(poll_w)
  );

  assign hs_active = act_w[0];
  assign vs_active = act_w[1];
  assign poll_flag = poll_w;
endmodule

// File: rtl/sync_activity_detector_chk.sv
`timescale 1ns/1ps
module sync_activity_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       meas_done,
  input logic       run,
  input logic       hold,
  input logic       oneshot,
  input logic       start,
  input logic       hs_active,
  input logic       vs_active,
  input logic       poll_flag,
  input logic [7:0] hcnt,
  input logic [7:0] vcnt,
  input logic [2:0] addr,
  input logic [3:0] rdata_hi
);
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done && oneshot |=> !start);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !meas_done);

  p_poll_flips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> poll_flag != $past(poll_flag));

  p_poll_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> $stable(poll_flag));

  p_result_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> $stable(hs_active) && $stable(vs_active));

  p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done && hold |=> $stable(hs_active) && $stable(vs_active));

  p_hold_oneshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot |-> !hold);

  p_hsat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && !meas_done && (hcnt == 8'hFF) |=> hcnt == 8'hFF);

  p_vsat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && !meas_done && (vcnt == 8'hFF) |=> vcnt == 8'hFF);

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd0) |-> rdata_hi == 4'h0);
endmodule

bind sync_activity_detector sync_activity_detector_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .meas_done(meas_done), .run(run_w),
  .hold(hold_w), .oneshot(ctrl_w.oneshot), .start(ctrl_w.start),
  .hs_active(hs_active), .vs_active(vs_active), .poll_flag(poll_flag),
  .hcnt(cnt_w[0]), .vcnt(cnt_w[1]), .addr(addr), .rdata_hi(rdata[7:4])
);

// File: tb/sync_activity_detector_bench.sv
`timescale 1ns/1ps
module sync_activity_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_in = 1'b0, vs_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       hs_active, vs_active, poll_flag;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  logic ready = 1'b0;
  logic last_poll = 1'b0;
  logic exp_poll = 1'b0, exp_h = 1'b0, exp_v = 1'b0;

  typedef struct {
    logic h;
    logic v;
    int   at;
    string req;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_activity_detector u_sync_activity_detector (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hs_active(hs_active),
    .vs_active(vs_active), .poll_flag(poll_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(req, int'(rdata), int'(exp));
  endtask

  // One measurement window of n clocks, entered at the negedge after its start edge.
  task automatic run_window(input int nh, input int oh, input int nv, input int ov,
                            input logic eh, input logic ev, input int n,
                            input logic do_wr, input logic [7:0] wv, input string req);
    item_t it;
    it.h = eh; it.v = ev; it.at = cyc + n; it.req = req;
    exp_q.push_back(it);
    exp_poll = ~exp_poll; exp_h = eh; exp_v = ev;
    for (int i = 0; i < n; i++) begin
      hs_in = (i >= oh) && (i < oh + 2*nh) && (((i - oh) % 2) == 0);
      vs_in = (i >= ov) && (i < ov + 2*nv) && (((i - ov) % 2) == 0);
      if (do_wr && i == 8) begin addr = 3'd0; wdata = wv; wr_en = 1'b1; end
      if (do_wr && i == 9) wr_en = 1'b0;
      @(negedge clk);
    end
    hs_in = 1'b0; vs_in = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: each polling toggle must match the oldest expected result.
  initial begin
    forever begin
      @(negedge clk);
      if (ready && (poll_flag !== last_poll)) begin
        last_poll = poll_flag;
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R3/R4 unexpected poll toggle act=1 exp=0");
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk({it.req, " R5 hs_active"}, int'(hs_active), int'(it.h));
          chk({it.req, " R5 vs_active"}, int'(vs_active), int'(it.v));
          chk({it.req, " R8 toggle cycle"}, cyc, it.at);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    n_err++;
    $display("FAIL R3 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(5);
    ready = 1'b1;

    // R1: reset state
    chk("R1 hs_active", int'(hs_active), 0);
    chk("R1 vs_active", int'(vs_active), 0);
    chk("R1 poll_flag", int'(poll_flag), 0);
    for (int a = 0; a < 8; a++) bus_rd(3'(a), 8'h00, "R1 register");

    // R2: map, reserved bits, read-only status
    bus_wr(3'd1, 8'h01); bus_wr(3'd2, 8'hA5); bus_wr(3'd3, 8'h02);
    bus_wr(3'd4, 8'h00); bus_wr(3'd5, 8'h04); bus_wr(3'd6, 8'h04);
    bus_rd(3'd2, 8'hA5, "R2 hwin high");
    bus_wr(3'd2, 8'h00);
    bus_rd(3'd1, 8'h01, "R2 hwin low");
    bus_rd(3'd3, 8'h02, "R2 vwin low");
    bus_rd(3'd5, 8'h04, "R2 hmin");
    bus_wr(3'd7, 8'hFF);
    bus_rd(3'd7, 8'h00, "R2 status read-only");
    bus_wr(3'd0, 8'hF0);
    bus_rd(3'd0, 8'h00, "R2 reserved bits");

    // R3/R5: single shot, both lines above minimum
    bus_wr(3'd0, 8'h03);
    run_window(5, 0, 5, 0, 1, 1, 512, 0, 8'h00, "R3");
    bus_rd(3'd0, 8'h01, "R3 start cleared");
    bus_rd(3'd7, {5'b0, exp_poll, exp_v, exp_h}, "R8 status");
    idle(700);

    // R5: one below and exactly at minimum
    bus_wr(3'd0, 8'h03);
    run_window(3, 0, 4, 0, 0, 1, 512, 0, 8'h00, "R5 threshold");

    // R6: horizontal window edge
    bus_wr(3'd5, 8'h01); bus_wr(3'd6, 8'h01);
    bus_wr(3'd0, 8'h03);
    run_window(3, 300, 0, 0, 0, 0, 512, 0, 8'h00, "R6 late hs");
    bus_wr(3'd0, 8'h03);
    run_window(1, 255, 1, 400, 1, 1, 512, 0, 8'h00, "R6 last inside");
    bus_wr(3'd0, 8'h03);
    run_window(1, 256, 1, 510, 0, 1, 512, 0, 8'h00, "R6 first outside");

    // R5: zero minimum
    bus_wr(3'd5, 8'h00); bus_wr(3'd6, 8'h00);
    bus_wr(3'd0, 8'h03);
    run_window(0, 0, 0, 0, 1, 1, 512, 0, 8'h00, "R5 zero min");

    // R7: saturation
    bus_wr(3'd1, 8'h03); bus_wr(3'd3, 8'h04);
    bus_wr(3'd5, 8'hFF); bus_wr(3'd6, 8'hFF);
    bus_wr(3'd0, 8'h03);
    run_window(300, 0, 200, 0, 1, 0, 1024, 0, 8'h00, "R7 saturate");

    // R10: hold ignored in single shot
    bus_wr(3'd1, 8'h01); bus_wr(3'd3, 8'h02);
    bus_wr(3'd5, 8'h02); bus_wr(3'd6, 8'h02);
    bus_wr(3'd0, 8'h07);
    run_window(0, 0, 3, 0, 0, 1, 512, 0, 8'h00, "R10 hold single");

    // R4/R9: continuous mode with hold
    bus_wr(3'd0, 8'h08);
    run_window(3, 0, 3, 0, 1, 1, 512, 0, 8'h00, "R4 run1");
    run_window(0, 0, 0, 0, 0, 0, 512, 0, 8'h00, "R4 run2");
    run_window(3, 0, 0, 0, 0, 0, 512, 1, 8'h0C, "R9 held1");
    run_window(3, 0, 3, 0, 0, 0, 512, 0, 8'h00, "R9 held2");
    run_window(0, 0, 3, 0, 0, 1, 512, 1, 8'h08, "R9 released");
    bus_wr(3'd0, 8'h00);
    idle(1500);
    chk("R4 stopped queue", exp_q.size(), 0);
    bus_rd(3'd7, {5'b0, exp_poll, exp_v, exp_h}, "R8 final status");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule